// File: doc/BRIEF.md
# Clock-Configuration Serial Register Slave

This block is the two-wire serial configuration port and mode logic of a four-output clock generator. It oversamples the SCL and SDA bus lines with a fast system clock and recognises START, repeated START and STOP conditions. It answers at one of four bus addresses, chosen by two strap pins. Through that port it holds two writable configuration bytes and one read-only identification byte. Both single-byte and two-byte transfers are supported, and the register index advances after every data byte.

From the stored configuration and two control pins, the block produces three results. The first is a decoded PLL multiplication ratio. The second is a reference-range select bit. The third is a two-bit drive mode for each of the four clock outputs. The analog PLL and the output drivers sit outside the block. The slave never holds SCL low. It tolerates a master that changes SDA in the same instant that SCL falls. It has no bus timeout and no packet error check.

Top module: `clkcfg_smb_slave`

## Requirements
- R1: The 7-bit slave address is {5'b11011, id_strap[1], id_strap[0]}, and the address byte carries the read/write flag in its LSB (1 = read). The slave pulls SDA low in the acknowledge slot only when the address matches. On a mismatch it leaves SDA released for that transfer and ignores all bytes until the next START, so no register changes.
- R2: After reset, command 0x80 reads 0x1F and command 0x81 reads 0x08.
- R3: Command 0x80 is fully read/write. Command 0x81 is read/write except bit 3, which always reads back 1 (writing 0x00 reads back 0x08).
- R4: Command 0x82 reads {REV_ID, 3'b010}, with REV_ID defaulting to 5'b00011 (0x1A). Writes to 0x82 are acknowledged and have no effect.
- R5: A write sends address, command and then data bytes. A read sends address+W, command, repeated START, address+R, and then receives data bytes. Each data byte increments the register index, so a two-byte transfer at 0x80 covers 0x80 and 0x81. A master ACK on a read byte requests the next byte, and a master NACK ends the read.
- R6: Any command code other than 0x80 to 0x82 is acknowledged. Data written to it is discarded, and a read of it returns 0x00.
- R7: Bits 6..4 of 0x80 select the ratio (mult_ok, mult_num/mult_den): 000=3/1, 001=4/1, 010=5/1, 011=6/1, 101=9/2, 111=15/4. For 100 and 110, mult_ok=0 and num=den=0.
- R8: When en_pin is low, every output mode is 2'b00 (high impedance), whatever the registers hold.
- R9: When en_pin is high and bypass_n is low, every output mode is 2'b10 (reference clock around the PLL). This takes priority over the test bit.
- R10: When en_pin and bypass_n are both high, bit 0 of 0x81 set to 1 makes every mode 2'b11 (reserved test). When that bit is 0, output k (mode bits out_mode[2k+1:2k]) is 2'b01 (PLL clock) if bit 3-k of 0x80 is 1, and 2'b00 otherwise.
- R11: ref_sel equals bit 2 of 0x81.
- R12: A START or repeated START in the middle of a byte abandons it without writing a register. After a STOP, SDA is released. The slave only changes its SDA drive while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain drive) |
| id_strap | input | 2 | Address strap pins, bits 1..0 of the address |
| en_pin | input | 1 | Output enable pin |
| bypass_n | input | 1 | Active-low PLL bypass pin |
| mult_num | output | 4 | Ratio numerator |
| mult_den | output | 3 | Ratio denominator |
| mult_ok | output | 1 | 1 when the selected ratio code is defined |
| ref_sel | output | 1 | Reference range select |
| out_mode | output | 8 | Two-bit mode per output: 00 high-Z, 01 PLL, 10 bypass, 11 test |

## Verification
A corrupted register index or shift state shows on SDA within one transfer. The data byte read back differs, or the acknowledge slot is released where a pull-down was due. A wrong stored configuration appears at once on mult_num, mult_den, ref_sel and out_mode, because those outputs decode the stored bytes without delay. A missed START or STOP appears on the next byte. The slave then acknowledges a foreign address or stays silent on its own.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

   typedef enum logic [1:0] {
      OM_HIZ  = 2'b00,
      OM_PLL  = 2'b01,
      OM_BYP  = 2'b10,
      OM_TEST = 2'b11
   } omode_t;

   typedef enum logic [3:0] {
      ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_CMD, ST_CMD_ACK,
      ST_WDAT, ST_WDAT_ACK, ST_RDAT, ST_RDAT_ACK
   } smb_st_t;

   localparam logic [7:0] CMD_CFG   = 8'h80;
   localparam logic [7:0] CMD_AUX   = 8'h81;
   localparam logic [7:0] CMD_IDENT = 8'h82;

   typedef struct packed {
      logic       ok;
      logic [3:0] num;
      logic [2:0] den;
   } ratio_t;

   function automatic ratio_t ratio_of(input logic [2:0] code);
      ratio_t r;
      case (code)
         3'b000:  r = '{1'b1, 4'd3,  3'd1};
         3'b001:  r = '{1'b1, 4'd4,  3'd1};
         3'b010:  r = '{1'b1, 4'd5,  3'd1};
         3'b011:  r = '{1'b1, 4'd6,  3'd1};
         3'b101:  r = '{1'b1, 4'd9,  3'd2};
         3'b111:  r = '{1'b1, 4'd15, 3'd4};
         default: r = '{1'b0, 4'd0,  3'd0};
      endcase
      return r;
   endfunction

   function automatic omode_t mode_of(input logic en, input logic byp_n,
                                      input logic test, input logic ena);
      omode_t m;
      if (!en)        m = OM_HIZ;
      else if (!byp_n) m = OM_BYP;
      else if (test)  m = OM_TEST;
      else if (ena)   m = OM_PLL;
      else            m = OM_HIZ;
      return m;
   endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
   parameter int SYNC_STAGES = 2,
   parameter int SDA_LAG     = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_p,
   output logic stop_p
);
   localparam int SDA_LEN = SYNC_STAGES + SDA_LAG;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("smb_line_sync: SYNC_STAGES must be at least 2");
      end
      if (SDA_LAG < 0) begin : g_bad_lag
         $error("smb_line_sync: SDA_LAG must not be negative");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] scl_ff;
   logic [SDA_LEN-1:0]     sda_ff;
   logic                   scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_ff <= '1;
         sda_ff <= '1;
         scl_q  <= 1'b1;
         sda_q  <= 1'b1;
      end else begin
         scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
         sda_ff <= {sda_ff[SDA_LEN-2:0], sda_i};
         scl_q  <= scl_s;
         sda_q  <= sda_s;
      end
   end

   assign scl_s    = scl_ff[SYNC_STAGES-1];
   assign sda_s    = sda_ff[SDA_LEN-1];
   assign scl_rise = scl_s & ~scl_q;
   assign scl_fall = ~scl_s & scl_q;
   assign start_p  = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_p   = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/smb_byte_engine.sv
module smb_byte_engine
   import clkcfg_pkg::*;
#(
   parameter int AW = 7,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] dev_addr,
   input  logic          sda_s,
   input  logic          scl_rise,
   input  logic          scl_fall,
   input  logic          start_p,
   input  logic          stop_p,
   input  logic [DW-1:0] rd_data,
   output logic [DW-1:0] rd_idx,
   output logic          wr_en,
   output logic [DW-1:0] wr_idx,
   output logic [DW-1:0] wr_data,
   output logic          sda_oe
);
   localparam int BW = $clog2(DW);
   localparam logic [BW-1:0] LAST = BW'(DW - 1);

   generate
      if (AW + 1 != DW) begin : g_bad_width
         $error("smb_byte_engine: address plus flag must fill one byte");
      end
   endgenerate

   smb_st_t       st;
   logic [DW-1:0] shreg;
   logic [DW-2:0] tx;
   logic [BW-1:0] bitcnt;
   logic          got_all, rw, m_ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         shreg   <= '0;
         tx      <= '0;
         bitcnt  <= '0;
         got_all <= 1'b0;
         rw      <= 1'b0;
         m_ack   <= 1'b0;
         rd_idx  <= '0;
         wr_en   <= 1'b0;
         wr_idx  <= '0;
         wr_data <= '0;
         sda_oe  <= 1'b0;
      end else begin
         wr_en <= 1'b0;
         if (start_p) begin
            st      <= ST_ADDR;
            bitcnt  <= '0;
            got_all <= 1'b0;
            sda_oe  <= 1'b0;
         end else if (stop_p) begin
            st     <= ST_IDLE;
            sda_oe <= 1'b0;
         end else begin
            case (st)
               ST_ADDR, ST_CMD, ST_WDAT: begin
                  if (scl_rise && !got_all) begin
                     shreg  <= {shreg[DW-2:0], sda_s};
                     bitcnt <= bitcnt + 1'b1;
                     if (bitcnt == LAST) got_all <= 1'b1;
                  end else if (scl_fall && got_all) begin
                     got_all <= 1'b0;
                     bitcnt  <= '0;
                     if (st == ST_ADDR) begin
                        if (shreg[DW-1:1] == dev_addr) begin
                           sda_oe <= 1'b1;
                           rw     <= shreg[0];
                           st     <= ST_ADDR_ACK;
                        end else begin
                           st <= ST_IDLE;
                        end
                     end else if (st == ST_CMD) begin
                        rd_idx <= shreg;
                        sda_oe <= 1'b1;
                        st     <= ST_CMD_ACK;
                     end else begin
                        wr_en   <= 1'b1;
                        wr_idx  <= rd_idx;
                        wr_data <= shreg;
                        rd_idx  <= rd_idx + 1'b1;
                        sda_oe  <= 1'b1;
                        st      <= ST_WDAT_ACK;
                     end
                  end
               end
               ST_ADDR_ACK: if (scl_fall) begin
                  bitcnt <= '0;
                  if (rw) begin
                     sda_oe <= ~rd_data[DW-1];
                     tx     <= rd_data[DW-2:0];
                     st     <= ST_RDAT;
                  end else begin
                     sda_oe <= 1'b0;
                     st     <= ST_CMD;
                  end
               end
               ST_CMD_ACK, ST_WDAT_ACK: if (scl_fall) begin
                  sda_oe <= 1'b0;
                  st     <= ST_WDAT;
               end
               ST_RDAT: if (scl_fall) begin
                  if (bitcnt == LAST) begin
                     sda_oe <= 1'b0;
                     bitcnt <= '0;
                     rd_idx <= rd_idx + 1'b1;
                     st     <= ST_RDAT_ACK;
                  end else begin
                     bitcnt <= bitcnt + 1'b1;
                     sda_oe <= ~tx[DW-2];
                     tx     <= {tx[DW-3:0], 1'b0};
                  end
               end
               ST_RDAT_ACK: begin
                  if (scl_rise) m_ack <= ~sda_s;
                  else if (scl_fall) begin
                     if (m_ack) begin
                        sda_oe <= ~rd_data[DW-1];
                        tx     <= rd_data[DW-2:0];
                        st     <= ST_RDAT;
                     end else begin
                        st <= ST_IDLE;
                     end
                  end
               end
               default: st <= ST_IDLE;
            endcase
         end
      end
   end

endmodule

// File: rtl/clkcfg_regfile.sv
module clkcfg_regfile
   import clkcfg_pkg::*;
#(
   parameter logic [4:0] REV_ID     = 5'b00011,
   parameter logic [2:0] VENDOR_ID  = 3'b010,
   parameter logic [7:0] CFG_RST    = 8'h1F,
   parameter logic [7:0] AUX_RST    = 8'h08,
   parameter logic [7:0] AUX_FORCE1 = 8'h08,
   parameter int         N_OUT      = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [7:0]       rd_idx,
   output logic [7:0]       rd_data,
   input  logic             wr_en,
   input  logic [7:0]       wr_idx,
   input  logic [7:0]       wr_data,
   output logic [2:0]       mult_sel,
   output logic [N_OUT-1:0] out_ena,
   output logic             ref_sel,
   output logic             test_mode
);
   generate
      if (N_OUT != 4) begin : g_bad_nout
         $error("clkcfg_regfile: the enable field holds exactly four outputs");
      end
   endgenerate

   logic [7:0] cfg_q, aux_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= CFG_RST;
         aux_q <= AUX_RST | AUX_FORCE1;
      end else if (wr_en) begin
         if (wr_idx == CMD_CFG) cfg_q <= wr_data;
         if (wr_idx == CMD_AUX) aux_q <= wr_data | AUX_FORCE1;
      end
   end

   always_comb begin
      case (rd_idx)
         CMD_CFG:   rd_data = cfg_q;
         CMD_AUX:   rd_data = aux_q;
         CMD_IDENT: rd_data = {REV_ID, VENDOR_ID};
         default:   rd_data = 8'h00;
      endcase
   end

   assign mult_sel  = cfg_q[6:4];
   assign out_ena   = cfg_q[N_OUT-1:0];
   assign ref_sel   = aux_q[2];
   assign test_mode = aux_q[0];

endmodule

// File: rtl/clkcfg_mode_dec.sv
module clkcfg_mode_dec
   import clkcfg_pkg::*;
#(
   parameter int N_OUT = 4
) (
   input  logic [2:0]         mult_sel,
   input  logic [N_OUT-1:0]   out_ena,
   input  logic               test_mode,
   input  logic               en_pin,
   input  logic               bypass_n,
   output logic [3:0]         mult_num,
   output logic [2:0]         mult_den,
   output logic               mult_ok,
   output logic [2*N_OUT-1:0] out_mode
);
   assign {mult_ok, mult_num, mult_den} = ratio_of(mult_sel);

   for (genvar k = 0; k < N_OUT; k++) begin : g_out
      assign out_mode[2*k +: 2] = mode_of(en_pin, bypass_n, test_mode,
                                          out_ena[N_OUT-1-k]);
   end

endmodule

// File: rtl/clkcfg_smb_slave.sv
module clkcfg_smb_slave #(
   parameter int         N_OUT       = 4,
   parameter int         SYNC_STAGES = 2,
   parameter int         SDA_LAG     = 1,
   parameter logic [4:0] ADDR_HI     = 5'b11011,
   parameter logic [4:0] REV_ID      = 5'b00011
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_i,
   input  logic               sda_i,
   output logic               sda_oe,
   input  logic [1:0]         id_strap,
   input  logic               en_pin,
   input  logic               bypass_n,
   output logic [3:0]         mult_num,
   output logic [2:0]         mult_den,
   output logic               mult_ok,
   output logic               ref_sel,
   output logic [2*N_OUT-1:0] out_mode
);
   logic             scl_s, sda_s, scl_rise, scl_fall, start_p, stop_p;
   logic [7:0]       rd_idx, rd_data, wr_idx, wr_data;
   logic             wr_en, test_mode;
   logic [2:0]       mult_sel;
   logic [N_OUT-1:0] out_ena;

   smb_line_sync #(.SYNC_STAGES(SYNC_STAGES), .SDA_LAG(SDA_LAG)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_p(start_p), .stop_p(stop_p));

   smb_byte_engine #(.AW(7), .DW(8)) u_eng (
      .clk(clk), .rst_n(rst_n), .dev_addr({ADDR_HI, id_strap}),
      .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_p(start_p), .stop_p(stop_p), .rd_data(rd_data),
      .rd_idx(rd_idx), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .sda_oe(sda_oe));

   clkcfg_regfile #(.REV_ID(REV_ID), .N_OUT(N_OUT)) u_regs (
      .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx), .rd_data(rd_data),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .mult_sel(mult_sel), .out_ena(out_ena), .ref_sel(ref_sel),
      .test_mode(test_mode));

   clkcfg_mode_dec #(.N_OUT(N_OUT)) u_dec (
      .mult_sel(mult_sel), .out_ena(out_ena), .test_mode(test_mode),
      .en_pin(en_pin), .bypass_n(bypass_n), .mult_num(mult_num),
      .mult_den(mult_den), .mult_ok(mult_ok), .out_mode(out_mode));

endmodule

// File: rtl/clkcfg_smb_chk.sv
module clkcfg_smb_chk #(
   parameter int N_OUT = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               en_pin,
   input logic               bypass_n,
   input logic [2*N_OUT-1:0] out_mode,
   input logic               sda_oe,
   input logic               scl_s,
   input logic               stop_p,
   input logic [2:0]         mult_sel,
   input logic               mult_ok,
   input logic               test_mode
);
   localparam logic [2*N_OUT-1:0] ALL_BYP  = {N_OUT{2'b10}};
   localparam logic [2*N_OUT-1:0] ALL_TEST = {N_OUT{2'b11}};

   AST_OFF_ALL_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
      !en_pin |-> out_mode == '0); // R8
   AST_BYPASS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      en_pin && !bypass_n |-> out_mode == ALL_BYP); // R9
   AST_TEST_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      en_pin && bypass_n && test_mode |-> out_mode == ALL_TEST); // R10
   AST_RATIO_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
      !mult_ok |-> (mult_sel == 3'b100 || mult_sel == 3'b110)); // R7
   AST_RELEASE_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      stop_p |=> !sda_oe); // R12
   AST_SDA_STILL_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      scl_s && $past(scl_s) && !stop_p |-> $stable(sda_oe)); // R12

endmodule

bind clkcfg_smb_slave clkcfg_smb_chk #(.N_OUT(N_OUT)) u_chk (
   .clk(clk), .rst_n(rst_n), .en_pin(en_pin), .bypass_n(bypass_n),
   .out_mode(out_mode), .sda_oe(sda_oe), .scl_s(scl_s), .stop_p(stop_p),
   .mult_sel(mult_sel), .mult_ok(mult_ok), .test_mode(test_mode));

// File: tb/sim_clkcfg_smb_slave.sv
module sim_clkcfg_smb_slave;
   localparam int H = 10;
   localparam logic [7:0] DW_ADDR = 8'hDC;
   localparam logic [7:0] DR_ADDR = 8'hDD;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1, sda_m = 1'b1;
   logic       en_pin = 1'b1, bypass_n = 1'b1;
   logic [1:0] id_strap = 2'b10;
   logic       sda_oe, sda_line, mult_ok, ref_sel;
   logic [3:0] mult_num;
   logic [2:0] mult_den;
   logic [7:0] out_mode;

   always #2 clk = ~clk;
   assign sda_line = sda_m & ~sda_oe;

   clkcfg_smb_slave u0 (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
      .sda_oe(sda_oe), .id_strap(id_strap), .en_pin(en_pin),
      .bypass_n(bypass_n), .mult_num(mult_num), .mult_den(mult_den),
      .mult_ok(mult_ok), .ref_sel(ref_sel), .out_mode(out_mode));

   int    n_cmp = 0, n_bad = 0;
   string exp_tag[$];
   int    exp_val[$];
   int    obs_val[$];

   task automatic expect_item(input string tag, input int v);
      exp_tag.push_back(tag);
      exp_val.push_back(v);
   endtask

   initial forever begin
      @(negedge clk);
      while (obs_val.size() > 0 && exp_val.size() > 0) begin
         automatic string t = exp_tag.pop_front();
         automatic int    e = exp_val.pop_front();
         automatic int    o = obs_val.pop_front();
         n_cmp++;
         if (o != e) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", t, o, e);
         end
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; scl_m = 1'b1; tick(H);
      sda_m = 1'b0; tick(H);
      scl_m = 1'b0;
   endtask

   task automatic bus_rstart();
      sda_m = 1'b1; tick(H);
      scl_m = 1'b1; tick(H);
      sda_m = 1'b0; tick(H);
      scl_m = 1'b0;
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; tick(H);
      scl_m = 1'b1; tick(H);
      sda_m = 1'b1; tick(H);
   endtask

   // data changes in the same step as the SCL fall: zero hold time
   task automatic put_bit(input logic b);
      sda_m = b; tick(H);
      scl_m = 1'b1; tick(H);
      scl_m = 1'b0;
   endtask

   task automatic get_bit(output logic b);
      sda_m = 1'b1; tick(H);
      scl_m = 1'b1; tick(H/2);
      b = sda_line; tick(H/2);
      scl_m = 1'b0;
   endtask

   task automatic wbyte(input logic [7:0] v, input string tag, input bit acked);
      logic a;
      expect_item(tag, acked ? 0 : 1);
      for (int i = 7; i >= 0; i--) put_bit(v[i]);
      get_bit(a);
      obs_val.push_back(int'(a));
   endtask

   task automatic rbyte(input logic [7:0] e, input string tag, input bit more);
      logic [7:0] v;
      logic       b;
      expect_item(tag, int'(e));
      for (int i = 7; i >= 0; i--) begin
         get_bit(b);
         v[i] = b;
      end
      obs_val.push_back(int'(v));
      put_bit(~more);
   endtask

   task automatic check_port(input string tag, input int e, input int a);
      expect_item(tag, e);
      obs_val.push_back(a);
   endtask

   task automatic wr_reg(input logic [7:0] cmd, input logic [7:0] d, input string tag);
      bus_start();
      wbyte(DW_ADDR, "R1", 1);
      wbyte(cmd, tag, 1);
      wbyte(d, tag, 1);
      bus_stop();
   endtask

   task automatic rd_reg(input logic [7:0] cmd, input logic [7:0] e, input string tag);
      bus_start();
      wbyte(DW_ADDR, "R1", 1);
      wbyte(cmd, tag, 1);
      bus_rstart();
      wbyte(DR_ADDR, "R1", 1);
      rbyte(e, tag, 0);
      bus_stop();
   endtask

   function automatic int ratio_word();
      return {24'd0, mult_ok, mult_num, mult_den};
   endfunction

   initial begin
      tick(5);
      rst_n = 1'b1;
      tick(5);
      // reset state
      check_port("R2", 8'hA1, ratio_word());
      check_port("R10", 8'h55, int'(out_mode));
      check_port("R11", 0, int'(ref_sel));
      rd_reg(8'h80, 8'h1F, "R2");
      rd_reg(8'h81, 8'h08, "R2");
      rd_reg(8'h82, 8'h1A, "R4");
      check_port("R12", 0, int'(sda_oe));

      // foreign address: no acknowledge, no write
      bus_start();
      wbyte(8'hD8, "R1", 0);
      wbyte(8'h80, "R1", 0);
      wbyte(8'h00, "R1", 0);
      bus_stop();
      rd_reg(8'h80, 8'h1F, "R1");

      // single byte write and its decode
      wr_reg(8'h80, 8'h0A, "R3");
      tick(4);
      check_port("R7", 8'h99, ratio_word());
      check_port("R10", 8'h11, int'(out_mode));
      rd_reg(8'h80, 8'h0A, "R3");

      // two-byte write and two-byte read
      bus_start();
      wbyte(DW_ADDR, "R5", 1);
      wbyte(8'h80, "R5", 1);
      wbyte(8'h5F, "R5", 1);
      wbyte(8'h04, "R5", 1);
      bus_stop();
      tick(4);
      check_port("R7", 8'hCA, ratio_word());
      check_port("R11", 1, int'(ref_sel));
      check_port("R10", 8'h55, int'(out_mode));
      bus_start();
      wbyte(DW_ADDR, "R5", 1);
      wbyte(8'h80, "R5", 1);
      bus_rstart();
      wbyte(DR_ADDR, "R5", 1);
      rbyte(8'h5F, "R5", 1);
      rbyte(8'h0C, "R5", 0);
      bus_stop();

      // forced bit of the auxiliary byte
      wr_reg(8'h81, 8'h00, "R3");
      rd_reg(8'h81, 8'h08, "R3");
      check_port("R11", 0, int'(ref_sel));

      // read-only identification and unimplemented code
      wr_reg(8'h82, 8'hFF, "R4");
      rd_reg(8'h82, 8'h1A, "R4");
      wr_reg(8'h90, 8'h55, "R6");
      rd_reg(8'h90, 8'h00, "R6");
      rd_reg(8'h80, 8'h5F, "R6");

      // ratio codes including reserved ones
      wr_reg(8'h80, 8'h4F, "R7");
      tick(4);
      check_port("R7", 8'h00, ratio_word());
      wr_reg(8'h80, 8'h6F, "R7");
      tick(4);
      check_port("R7", 8'h00, ratio_word());
      wr_reg(8'h80, 8'h7F, "R7");
      tick(4);
      check_port("R7", 8'hFC, ratio_word());
      wr_reg(8'h80, 8'h3F, "R7");
      tick(4);
      check_port("R7", 8'hB1, ratio_word());

      // pin driven modes
      en_pin = 1'b0; tick(1);
      check_port("R8", 8'h00, int'(out_mode));
      en_pin = 1'b1; bypass_n = 1'b0; tick(1);
      check_port("R9", 8'hAA, int'(out_mode));
      bypass_n = 1'b1;
      wr_reg(8'h81, 8'h01, "R10");
      tick(4);
      check_port("R10", 8'hFF, int'(out_mode));
      bypass_n = 1'b0; tick(1);
      check_port("R9", 8'hAA, int'(out_mode));
      en_pin = 1'b0; tick(1);
      check_port("R8", 8'h00, int'(out_mode));
      en_pin = 1'b1; bypass_n = 1'b1;

      // START inside a data byte abandons it
      bus_start();
      wbyte(DW_ADDR, "R12", 1);
      wbyte(8'h80, "R12", 1);
      put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
      bus_rstart();
      wbyte(DR_ADDR, "R12", 1);
      rbyte(8'h3F, "R12", 0);
      bus_stop();
      tick(4);
      check_port("R12", 0, int'(sda_oe));

      tick(20);
      if (exp_val.size() != 0 || obs_val.size() != 0) begin
         n_bad++;
         $display("FAIL scoreboard: actual %0d left expected 0", exp_val.size());
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule